// File: doc/BRIEF.md
# PCIe Link Bring-Up Sequencer

This controller walks a downstream PCIe device and its link through power-on. A start command puts the device into reset on the PERST# pin, active low. One cycle later it turns on the link-training enable that drives the external training state machine. It then counts a settle interval whose length is a parameter in clock cycles. When the interval ends it releases PERST#. From that point it watches three inputs: the physical-layer link-up flag, the data-link-layer link-up flag and the 6-bit training state code. It reports a usable link only when both flags are set and the code equals the value for a trained link.

Alongside the level indication, the block produces two one-cycle events. A link-up event fires when the data-link flag turns on while the physical flag is already on. A link-down event fires when a hot-reset or link-down reset indication rises. A stop command turns training off. A start command issued at any time restarts the whole sequence. All outputs are registered, and reset is synchronous and active high.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, train_en=0, perst_n=0, link_ok=0, up_pulse=0 and down_pulse=0.
- R2: After a clock edge that samples start_cmd=1, perst_n=0 and train_en=0. On the following edge train_en becomes 1, so the device is in reset before training is enabled.
- R3: perst_n goes to 1 exactly SETTLE_CYCLES clock cycles after train_en goes to 1, provided no start or stop intervenes.
- R4: Once perst_n is released and training is on, link_ok becomes 1 one cycle after phy_up=1, dll_up=1 and train_state equal UP_CODE (default 6'h11) are sampled together. It returns to 0 one cycle after that condition fails. During the settle interval link_ok stays 0 whatever the link inputs are.
- R5: An edge that samples stop_cmd=1 and start_cmd=0 leaves train_en=0 and link_ok=0 and does not change perst_n. When start_cmd and stop_cmd are both 1, the start wins.
- R6: up_pulse is 1 for exactly one cycle after an edge that samples dll_up rising (0 on the previous edge, 1 now) with phy_up=1 and train_en=1. The training code does not affect it. With train_en=0 no pulse occurs.
- R7: down_pulse is 1 for exactly one cycle after an edge that samples reset_event rising while train_en=1, even if reset_event stays high.
- R8: A start command in any state, including link-up, drives perst_n and link_ok to 0 and repeats the R2 and R3 sequence.
- R9: If either flag is 0, or the code differs from UP_CODE (for example 6'h10), link_ok stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_cmd | input | 1 | Begin or restart the bring-up sequence |
| stop_cmd | input | 1 | Turn link training off |
| phy_up | input | 1 | Physical-layer link-up flag |
| dll_up | input | 1 | Data-link-layer link-up flag |
| train_state | input | STATE_W | Current training state code |
| reset_event | input | 1 | Hot-reset or link-down reset indication |
| train_en | output | 1 | Link-training enable |
| perst_n | output | 1 | Device reset pin, low = held in reset |
| link_ok | output | 1 | Link is qualified as usable |
| up_pulse | output | 1 | One-cycle link-up event |
| down_pulse | output | 1 | One-cycle link-down event |

## Verification
The bench builds the block with SETTLE_CYCLES=8 instead of the 100 ms default. This lets it measure the whole reset-hold interval cycle by cycle and run several full restart sequences within a short run. UP_CODE keeps its default of 6'h11, so the bench can present neighbouring codes such as 6'h10 and show that they never qualify. With a settle count this small, a start or stop arriving in the middle of the hold interval and a restart from the link-up state both become cheap to reach.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET_HOLD,
    ST_WAIT_LINK,
    ST_LINK_UP,
    ST_STOPPED
  } seq_state_t;
endpackage

// File: rtl/lbs_settle_timer.sv
// Counts cycles of enabled training during reset hold; hit flags the last one.
module lbs_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == LAST);
endmodule

// File: rtl/lbs_link_qual.sv
// Link qualification and registered single-cycle event generation.
module lbs_link_qual #(
  parameter int unsigned STATE_W = 6,
  parameter logic [STATE_W-1:0] UP_CODE = 6'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic               phy_up,
  input  logic               dll_up,
  input  logic [STATE_W-1:0] train_state,
  input  logic               reset_event,
  output logic               qual_now,
  output logic               up_pulse,
  output logic               down_pulse
);
  logic dll_q;
  logic evt_q;

  assign qual_now = phy_up && dll_up && (train_state == UP_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      dll_q      <= 1'b0;
      evt_q      <= 1'b0;
      up_pulse   <= 1'b0;
      down_pulse <= 1'b0;
    end else begin
      dll_q      <= dll_up;
      evt_q      <= reset_event;
      up_pulse   <= arm && dll_up && !dll_q && phy_up;
      down_pulse <= arm && reset_event && !evt_q;
    end
  end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 5_000_000,
  parameter int unsigned STATE_W = 6,
  parameter logic [STATE_W-1:0] UP_CODE = 6'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  input  logic               phy_up,
  input  logic               dll_up,
  input  logic [STATE_W-1:0] train_state,
  input  logic               reset_event,
  output logic               train_en,
  output logic               perst_n,
  output logic               link_ok,
  output logic               up_pulse,
  output logic               down_pulse
);
  seq_state_t state;
  logic       settle_hit;
  logic       qual_now;
  logic       tmr_clr;
  logic       tmr_en;

  assign tmr_clr = start_cmd || (state != ST_RESET_HOLD);
  assign tmr_en  = (state == ST_RESET_HOLD) && train_en;

  lbs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk (clk),
    .clr (tmr_clr),
    .en  (tmr_en),
    .hit (settle_hit)
  );

  lbs_link_qual #(.STATE_W(STATE_W), .UP_CODE(UP_CODE)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .arm         (train_en),
    .phy_up      (phy_up),
    .dll_up      (dll_up),
    .train_state (train_state),
    .reset_event (reset_event),
    .qual_now    (qual_now),
    .up_pulse    (up_pulse),
    .down_pulse  (down_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      train_en <= 1'b0;
      perst_n  <= 1'b0;
      link_ok  <= 1'b0;
    end else if (start_cmd) begin
      state    <= ST_RESET_HOLD;
      train_en <= 1'b0;
      perst_n  <= 1'b0;
      link_ok  <= 1'b0;
    end else if (stop_cmd) begin
      state    <= ST_STOPPED;
      train_en <= 1'b0;
      link_ok  <= 1'b0;
    end else begin
      case (state)
        ST_RESET_HOLD: begin
          train_en <= 1'b1;
          if (settle_hit) begin
            perst_n <= 1'b1;
            state   <= ST_WAIT_LINK;
          end
        end
        ST_WAIT_LINK: begin
          if (qual_now) begin
            link_ok <= 1'b1;
            state   <= ST_LINK_UP;
          end
        end
        ST_LINK_UP: begin
          if (!qual_now) begin
            link_ok <= 1'b0;
            state   <= ST_WAIT_LINK;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int unsigned STATE_W = 6,
  parameter logic [STATE_W-1:0] UP_CODE = 6'h11
) (
  input logic               clk,
  input logic               rst,
  input logic               start_cmd,
  input logic               stop_cmd,
  input logic               phy_up,
  input logic               dll_up,
  input logic [STATE_W-1:0] train_state,
  input logic               reset_event,
  input logic               train_en,
  input logic               perst_n,
  input logic               link_ok,
  input logic               up_pulse,
  input logic               down_pulse
);
  AST_START_RESETS: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> (!perst_n && !train_en && !link_ok)); // R2
  AST_TRAIN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(train_en) |-> !perst_n); // R2
  AST_RELEASE_IN_TRAINING: assert property (@(posedge clk) disable iff (rst)
    $rose(perst_n) |-> (train_en && $past(train_en))); // R3
  AST_LINK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    link_ok |-> ($past(phy_up && dll_up && (train_state == UP_CODE)) && perst_n)); // R4
  AST_STOP_KILLS_TRAIN: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && !start_cmd) |=> (!train_en && !link_ok && $stable(perst_n))); // R5
  AST_UP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    up_pulse |=> !up_pulse); // R6
  AST_DOWN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    down_pulse |=> !down_pulse); // R7
  AST_DOWN_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    down_pulse |-> $past(reset_event)); // R7
endmodule

bind link_bringup_seq lbs_checker #(.STATE_W(STATE_W), .UP_CODE(UP_CODE)) u_lbs_chk (
  .clk         (clk),
  .rst         (rst),
  .start_cmd   (start_cmd),
  .stop_cmd    (stop_cmd),
  .phy_up      (phy_up),
  .dll_up      (dll_up),
  .train_state (train_state),
  .reset_event (reset_event),
  .train_en    (train_en),
  .perst_n     (perst_n),
  .link_ok     (link_ok),
  .up_pulse    (up_pulse),
  .down_pulse  (down_pulse)
);

// File: tb/test_link_bringup_seq.sv
module test_link_bringup_seq;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_cmd = 0, stop_cmd = 0, phy_up = 0, dll_up = 0, reset_event = 0;
  logic [5:0] train_state = 6'h00;
  logic train_en, perst_n, link_ok, up_pulse, down_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  link_bringup_seq #(.SETTLE_CYCLES(S)) i_link_bringup_seq (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .phy_up(phy_up), .dll_up(dll_up), .train_state(train_state),
    .reset_event(reset_event), .train_en(train_en), .perst_n(perst_n),
    .link_ok(link_ok), .up_pulse(up_pulse), .down_pulse(down_pulse));

  // Behavioural reference model: phase 0 idle, 1 hold, 2 waiting, 3 up, 4 stopped
  int phase = 0, elapsed = 0;
  bit m_train = 0, m_perst = 0, m_ok = 0, m_up = 0, m_dn = 0, m_dllp = 0, m_evtp = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; elapsed = 0; m_train = 0; m_perst = 0; m_ok = 0;
      m_up = 0; m_dn = 0; m_dllp = 0; m_evtp = 0;
    end else begin
      bit good, nu, nd;
      good = phy_up && dll_up && (train_state == 6'h11);
      nu = m_train && dll_up && !m_dllp && phy_up;
      nd = m_train && reset_event && !m_evtp;
      m_dllp = dll_up; m_evtp = reset_event;
      if (start_cmd) begin
        phase = 1; elapsed = 0; m_train = 0; m_perst = 0; m_ok = 0;
      end else if (stop_cmd) begin
        phase = 4; m_train = 0; m_ok = 0;
      end else if (phase == 1) begin
        if (m_train) elapsed++;
        m_train = 1;
        if (elapsed == S) begin m_perst = 1; phase = 2; end
      end else if (phase == 2 || phase == 3) begin
        m_ok = good; phase = good ? 3 : 2;
      end
      m_up = nu; m_dn = nd;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 train_en model", train_en, m_train);
      chk("R3 perst_n model", perst_n, m_perst);
      chk("R4 link_ok model", link_ok, m_ok);
      chk("R6 up_pulse model", up_pulse, m_up);
      chk("R7 down_pulse model", down_pulse, m_dn);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start_cmd = 1; step(1); start_cmd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    step(3);
    chk("R1 train_en in reset", train_en, 1'b0);
    chk("R1 perst_n in reset", perst_n, 1'b0);
    rst = 0;
    step(1);
    chk("R1 train_en", train_en, 1'b0);
    chk("R1 perst_n", perst_n, 1'b0);
    chk("R1 link_ok", link_ok, 1'b0);
    chk("R1 pulses", up_pulse | down_pulse, 1'b0);

    // Start; qualifying inputs during hold must not raise link_ok
    phy_up = 1; train_state = 6'h11;
    do_start();
    chk("R2 perst low after start", perst_n, 1'b0);
    chk("R2 train still off", train_en, 1'b0);
    dll_up = 1;
    step(1);
    chk("R2 train on", train_en, 1'b1);
    n = 0;
    while (!perst_n && n < 100) begin step(1); n++; chk("R4 no link in hold", link_ok, perst_n & 1'b0 | (perst_n ? link_ok : 1'b0)); end
    checks++;
    if (n != S) begin errors++; $display("FAIL R3 settle: actual=%0d expected=%0d", n, S); end
    step(1);
    chk("R4 link up", link_ok, 1'b1);

    // R9 code mismatch and single flag
    train_state = 6'h10; step(2);
    chk("R9 code 0x10", link_ok, 1'b0);
    train_state = 6'h11; phy_up = 0; step(2);
    chk("R9 phy low", link_ok, 1'b0);
    dll_up = 0; step(1);
    // R6 rising dll with phy high but wrong code
    phy_up = 1; train_state = 6'h05; dll_up = 1; step(1);
    chk("R6 up pulse", up_pulse, 1'b1);
    step(1);
    chk("R6 pulse ends", up_pulse, 1'b0);
    train_state = 6'h11; step(2);
    chk("R4 link back", link_ok, 1'b1);

    // R7 long reset_event gives one pulse
    reset_event = 1; step(1);
    chk("R7 down pulse", down_pulse, 1'b1);
    step(2);
    chk("R7 single", down_pulse, 1'b0);
    reset_event = 0;

    // R8 restart from link-up
    do_start();
    chk("R8 perst low", perst_n, 1'b0);
    chk("R8 link drop", link_ok, 1'b0);
    step(S + 4);
    chk("R8 relinked", link_ok, 1'b1);

    // R5 stop
    stop_cmd = 1; step(1); stop_cmd = 0;
    chk("R5 train off", train_en, 1'b0);
    chk("R5 link off", link_ok, 1'b0);
    chk("R5 perst kept", perst_n, 1'b1);
    dll_up = 0; step(1); dll_up = 1; step(1);
    chk("R6 no pulse when stopped", up_pulse, 1'b0);
    reset_event = 1; step(1); reset_event = 0;
    chk("R7 no pulse when stopped", down_pulse, 1'b0);

    // R5 start beats stop; also stop in mid-hold
    start_cmd = 1; stop_cmd = 1; step(1); start_cmd = 0; stop_cmd = 0;
    step(1);
    chk("R5 start priority", train_en, 1'b1);
    step(3);
    stop_cmd = 1; step(1); stop_cmd = 0;
    step(S + 2);
    chk("R5 stop in hold keeps reset", perst_n, 1'b0);
    chk("R5 stop in hold train", train_en, 1'b0);
    do_start();
    step(S + 6);
    chk("R8 final link", link_ok, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule